// File: doc/BRIEF.md
# Transmit Descriptor Poller

This block walks a circular ring of transmit descriptors held in a shared 16-bit memory and turns each ready descriptor into a byte stream. A one-cycle demand pulse starts a poll at the ring slot where the previous poll stopped. For every descriptor the controller owns and that marks a whole single-buffer frame, the block fetches the buffer pointer and the byte count. It then reads the buffer one byte per cycle and presents the bytes on a valid/last output. Short frames are optionally extended with zero bytes. When a frame is done, the block clears the descriptor's error word and hands the descriptor back to the host with retry flags filled in. It then raises a one-cycle transmit interrupt and moves on to the next slot.

Each descriptor occupies four consecutive memory words at `ring_base + 4*slot`. Word 0 holds buffer byte-address bits 15:0. Word 1 holds the status flags in bits 15:8 and buffer address bits 23:16 in bits 7:0. Word 2 holds the negated byte count in bits 11:0, and word 3 is the error word. Polling continues from slot to slot and halts at the first descriptor that is not ready. The line-side engine, collisions and retries are outside the block; the three retry flags arrive as inputs.

Top module: `tdp_tx_poller`

## Requirements
- R1: While reset is held and on the first cycles after it is released, the block issues no memory request, no output byte and no interrupt. It stays idle until a demand pulse arrives.
- R2: A demand pulse makes the block read word 1 of the descriptor at the current slot, at address `ring_base + 4*slot + 1`. Read data is taken from `mem_rdata` in the cycle after the request.
- R3: A descriptor qualifies only when word 1 has bit 15 (controller owns), bit 9 (frame start) and bit 8 (frame end) all set. A non-qualifying descriptor ends the poll with no byte output and no memory write, and the slot index is kept.
- R4: The frame length is 4096 minus word 2 bits 11:0, so a field of 0 means 4096. Bytes are read from the 24-bit byte address {word1[7:0], word0} upward and output one per cycle with no gaps. An even byte address selects the low byte of a memory word and an odd one selects the high byte.
- R5: `tx_last` is high only together with the final output byte of each frame.
- R6: When `pad_en` is 1 and the length is below MIN_LEN, zero bytes follow the data until MIN_LEN bytes have been output. Otherwise exactly the length is output.
- R7: After the final byte, the next cycle writes 0 to word 3. The cycle after that writes word 1 with bit 15 cleared, bits 14:13 cleared, bit 12/11/10 taken from `st_multi_retry`/`st_one_retry`/`st_defer`, bits 9:8 set and bits 7:0 kept. The cycle after that pulses `tx_int` high for exactly one cycle.
- R8: After each completed frame the slot index advances modulo 2^RING_LOG and the next descriptor is examined. A descriptor the host owns (bit 15 clear) stops the poll and is left unmodified.
- R9: A demand pulse that arrives while a poll is in progress is remembered. When the poll stops, a new poll starts at the stopping slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_demand | input | 1 | One-cycle request to poll the ring |
| pad_en | input | 1 | Enable zero padding of short frames |
| ring_base | input | 23 | Word address of slot 0 of the ring |
| st_defer | input | 1 | Deferred-transmission flag for write-back (bit 10) |
| st_one_retry | input | 1 | Single-retry flag for write-back (bit 11) |
| st_multi_retry | input | 1 | Multiple-retry flag for write-back (bit 12) |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 23 | Memory word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after a read request |
| tx_valid | output | 1 | Output byte valid |
| tx_data | output | 8 | Output byte |
| tx_last | output | 1 | Final byte of a frame |
| tx_int | output | 1 | One-cycle frame-completion pulse |

## Verification
The bench builds the block with RING_LOG = 2 and MIN_LEN = 20. A four-slot ring lets runs of up to three frames wrap the slot index within a few polls. A 20-byte minimum keeps padded frames short, so the pad and no-pad sides of the boundary (lengths 19, 20 and 21) and frames of one byte fit in a handful of cycles. Random frame lengths, odd buffer starts and retry flags are mixed with directed runs: a descriptor that is owned but incomplete, and a demand that lands mid-frame.

// File: rtl/tdp_pkg.sv
package tdp_pkg;

  localparam int DW          = 16;
  localparam int BA_W        = 24;
  localparam int AW          = BA_W - 1;
  localparam int LEN_W       = 13;
  localparam int CNT_FIELD_W = 12;

  localparam int OWN_B   = 15;
  localparam int MULTI_B = 12;
  localparam int ONE_B   = 11;
  localparam int DEFER_B = 10;
  localparam int STP_B   = 9;
  localparam int ENP_B   = 8;

  typedef enum logic [1:0] {
    WD_ADDR_LO = 2'd0,
    WD_STATUS  = 2'd1,
    WD_COUNT   = 2'd2,
    WD_ERR     = 2'd3
  } word_sel_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_FETCH,
    ST_CHKST,
    ST_GETLO,
    ST_GETCNT,
    ST_BREQ,
    ST_BOUT,
    ST_PAD,
    ST_CLRERR,
    ST_RELEASE,
    ST_NOTIFY
  } poll_state_e;

endpackage

// File: rtl/tdp_rst_sync.sv
module tdp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '0;
    end else begin
      pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = pipe_q[STAGES-1];

endmodule

// File: rtl/tdp_ring_index.sv
module tdp_ring_index #(
  parameter int RING_LOG = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                adv,
  output logic [RING_LOG-1:0] idx
);

  logic [RING_LOG-1:0] idx_q;
  logic [RING_LOG-1:0] idx_d;

  // wraps by width: ring size is a power of two
  always_comb begin
    idx_d = idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (adv) begin
      idx_q <= idx_d;
    end
  end

  assign idx = idx_q;

endmodule

// File: rtl/tdp_frame_len.sv
module tdp_frame_len
  import tdp_pkg::*;
#(
  parameter int MIN_LEN = 60
) (
  input  logic [CNT_FIELD_W-1:0] cnt_field,
  input  logic                   pad_en,
  output logic [LEN_W-1:0]       data_len,
  output logic [LEN_W-1:0]       frame_len
);

  localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_LEN);
  localparam logic [LEN_W-1:0] SPAN  = LEN_W'(1 << CNT_FIELD_W);

  always_comb begin
    data_len  = SPAN - {1'b0, cnt_field};
    frame_len = (pad_en && (data_len < MIN_L)) ? MIN_L : data_len;
  end

endmodule

// File: rtl/tdp_tx_poller.sv
module tdp_tx_poller
  import tdp_pkg::*;
#(
  parameter int RING_LOG = 4,
  parameter int MIN_LEN  = 60
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tx_demand,
  input  logic            pad_en,
  input  logic [AW-1:0]   ring_base,
  input  logic            st_defer,
  input  logic            st_one_retry,
  input  logic            st_multi_retry,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  output logic            tx_valid,
  output logic [7:0]      tx_data,
  output logic            tx_last,
  output logic            tx_int
);

  localparam int OFS_W = RING_LOG + 2;

  // reset: asserted asynchronously, released on the clock
  logic rst_n_s;

  tdp_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  // state
  poll_state_e      state_q, state_d;
  logic             pend_q, pend_d;
  logic [7:0]       addr_hi_q;
  logic [15:0]      addr_lo_q;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic [LEN_W-1:0] dlen_q, flen_q;
  logic             sel_q;

  // control strobes
  logic             ld_hi, ld_lo, ld_len, cnt_en, use_buf, adv;
  word_sel_e        wsel;
  logic [RING_LOG-1:0] idx;
  logic [LEN_W-1:0] dec_dlen, dec_flen;
  logic [LEN_W-1:0] rd_off;
  logic [BA_W-1:0]  buf_ba;
  logic [OFS_W-1:0] desc_ofs;
  logic [AW-1:0]    desc_addr;
  logic             eligible;
  logic             last_byte;
  logic             more_data;
  logic [DW-1:0]    wb_status;

  tdp_ring_index #(.RING_LOG(RING_LOG)) u_ring_index (
    .clk   (clk),
    .rst_n (rst_n_s),
    .adv   (adv),
    .idx   (idx)
  );

  tdp_frame_len #(.MIN_LEN(MIN_LEN)) u_frame_len (
    .cnt_field (mem_rdata[CNT_FIELD_W-1:0]),
    .pad_en    (pad_en),
    .data_len  (dec_dlen),
    .frame_len (dec_flen)
  );

  // address generation
  always_comb begin
    rd_off = (state_q == ST_BOUT) ? (cnt_q + 1'b1) : cnt_q;
  end

  assign buf_ba    = {addr_hi_q, addr_lo_q} + BA_W'(rd_off);
  assign desc_ofs  = {idx, wsel};
  assign desc_addr = ring_base + AW'(desc_ofs);
  assign mem_addr  = use_buf ? buf_ba[BA_W-1:1] : desc_addr;

  assign eligible  = mem_rdata[OWN_B] & mem_rdata[STP_B] & mem_rdata[ENP_B];
  assign last_byte = (cnt_q == (flen_q - 1'b1));
  assign more_data = ((cnt_q + 1'b1) < dlen_q);

  always_comb begin
    wb_status             = '0;
    wb_status[7:0]        = addr_hi_q;
    wb_status[ENP_B]      = 1'b1;
    wb_status[STP_B]      = 1'b1;
    wb_status[DEFER_B]    = st_defer;
    wb_status[ONE_B]      = st_one_retry;
    wb_status[MULTI_B]    = st_multi_retry;
  end

  // next-state logic
  always_comb begin
    state_d   = state_q;
    pend_d    = pend_q | (tx_demand & (state_q != ST_IDLE));
    cnt_d     = cnt_q;
    ld_hi     = 1'b0;
    ld_lo     = 1'b0;
    ld_len    = 1'b0;
    cnt_en    = 1'b0;
    use_buf   = 1'b0;
    adv       = 1'b0;
    wsel      = WD_STATUS;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_wdata = '0;
    tx_valid  = 1'b0;
    tx_data   = '0;
    tx_last   = 1'b0;
    tx_int    = 1'b0;

    case (state_q)
      ST_IDLE: begin
        if (tx_demand) begin
          state_d = ST_FETCH;
          pend_d  = 1'b0;
        end
      end

      ST_FETCH: begin
        mem_req = 1'b1;
        wsel    = WD_STATUS;
        state_d = ST_CHKST;
      end

      ST_CHKST: begin
        if (eligible) begin
          ld_hi   = 1'b1;
          mem_req = 1'b1;
          wsel    = WD_ADDR_LO;
          state_d = ST_GETLO;
        end else begin
          pend_d  = 1'b0;
          state_d = (pend_q || tx_demand) ? ST_FETCH : ST_IDLE;
        end
      end

      ST_GETLO: begin
        ld_lo   = 1'b1;
        mem_req = 1'b1;
        wsel    = WD_COUNT;
        state_d = ST_GETCNT;
      end

      ST_GETCNT: begin
        ld_len  = 1'b1;
        cnt_en  = 1'b1;
        cnt_d   = '0;
        state_d = ST_BREQ;
      end

      ST_BREQ: begin
        mem_req = 1'b1;
        use_buf = 1'b1;
        state_d = ST_BOUT;
      end

      ST_BOUT: begin
        tx_valid = 1'b1;
        tx_data  = sel_q ? mem_rdata[15:8] : mem_rdata[7:0];
        tx_last  = last_byte;
        cnt_en   = 1'b1;
        cnt_d    = cnt_q + 1'b1;
        if (last_byte) begin
          state_d = ST_CLRERR;
        end else if (more_data) begin
          mem_req = 1'b1;
          use_buf = 1'b1;
        end else begin
          state_d = ST_PAD;
        end
      end

      ST_PAD: begin
        tx_valid = 1'b1;
        tx_last  = last_byte;
        cnt_en   = 1'b1;
        cnt_d    = cnt_q + 1'b1;
        if (last_byte) begin
          state_d = ST_CLRERR;
        end
      end

      ST_CLRERR: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        wsel      = WD_ERR;
        mem_wdata = '0;
        state_d   = ST_RELEASE;
      end

      ST_RELEASE: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        wsel      = WD_STATUS;
        mem_wdata = wb_status;
        state_d   = ST_NOTIFY;
      end

      ST_NOTIFY: begin
        tx_int  = 1'b1;
        adv     = 1'b1;
        state_d = ST_FETCH;
      end

      default: begin
        state_d = ST_IDLE;
        pend_d  = 1'b0;
      end
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q   <= ST_IDLE;
      pend_q    <= 1'b0;
      addr_hi_q <= '0;
      addr_lo_q <= '0;
      cnt_q     <= '0;
      dlen_q    <= '0;
      flen_q    <= '0;
      sel_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      if (ld_hi) begin
        addr_hi_q <= mem_rdata[7:0];
      end
      if (ld_lo) begin
        addr_lo_q <= mem_rdata;
      end
      if (ld_len) begin
        dlen_q <= dec_dlen;
        flen_q <= dec_flen;
      end
      if (cnt_en) begin
        cnt_q <= cnt_d;
      end
      if (use_buf) begin
        sel_q <= buf_ba[0];
      end
    end
  end

endmodule

// File: rtl/tdp_tx_poller_chk.sv
module tdp_tx_poller_chk
  import tdp_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_we,
  input logic [DW-1:0] mem_wdata,
  input logic          tx_valid,
  input logic          tx_last,
  input logic          tx_int
);

  // R1: quiet on the edge where reset is released
  p_quiet_after_reset_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (!mem_req && !tx_valid && !tx_int));

  // R5: last only travels with a valid byte
  p_last_needs_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_last |-> tx_valid);

  // R5: no descriptor write while bytes stream
  p_no_write_in_stream_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !(mem_req && mem_we));

  // R7: error word cleared right after the last byte
  p_clear_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_last) |=> (mem_req && mem_we && (mem_wdata == '0)));

  // R7: ownership returned two cycles after the last byte
  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tx_valid && tx_last, 2) |-> (mem_req && mem_we && !mem_wdata[OWN_B]));

  // R7: interrupt follows the write-back sequence
  p_int_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_int |-> $past(tx_valid && tx_last, 3));

  // R7: interrupt is a single-cycle pulse
  p_int_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_int |=> !tx_int);

endmodule

bind tdp_tx_poller tdp_tx_poller_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_wdata (mem_wdata),
  .tx_valid  (tx_valid),
  .tx_last   (tx_last),
  .tx_int    (tx_int)
);

// File: tb/test_tdp_tx_poller.sv
`timescale 1ns/1ps
module test_tdp_tx_poller;

  localparam int RING_LOG = 2;
  localparam int NSLOT    = 1 << RING_LOG;
  localparam int MIN_LEN  = 20;
  localparam int RB       = 16;
  localparam int BUF0     = 512;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tx_demand;
  logic        pad_en;
  logic [22:0] ring_base;
  logic        st_defer, st_one_retry, st_multi_retry;
  logic        mem_req, mem_we;
  logic [22:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        tx_last;
  logic        tx_int;

  always #4 clk = ~clk;

  tdp_tx_poller #(.RING_LOG(RING_LOG), .MIN_LEN(MIN_LEN)) i_tdp_tx_poller (
    .clk(clk), .rst_n(rst_n), .tx_demand(tx_demand), .pad_en(pad_en),
    .ring_base(ring_base), .st_defer(st_defer), .st_one_retry(st_one_retry),
    .st_multi_retry(st_multi_retry), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_int(tx_int)
  );

  // memory model: one-cycle read latency
  logic [15:0] mem [0:1023];
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[9:0]];
    end
  end

  int checks = 0;
  int errs   = 0;
  bit done   = 1'b0;

  // monitor state
  logic [7:0] cap_data [0:255];
  bit         cap_last [0:255];
  int cap_n, int_n, wr_n, seq, seq_err, watch_n, first_addr;
  int watch_addr;
  bit armed;

  always @(negedge clk) begin
    if (rst_n) begin
      if (tx_valid && cap_n < 256) begin
        cap_data[cap_n] = tx_data;
        cap_last[cap_n] = tx_last;
        cap_n++;
      end
      if (tx_int) int_n++;
      if (mem_req && mem_we) wr_n++;
      if (mem_req && !mem_we && int'(mem_addr) == watch_addr) watch_n++;
      if (armed && mem_req && !mem_we) begin
        first_addr = int'(mem_addr);
        armed = 1'b0;
      end
      case (seq)
        0: if (tx_valid && tx_last) seq = 1;
        1: begin
          if (mem_req && mem_we && mem_wdata == 16'h0 && mem_addr[1:0] == 2'd3) seq = 2;
          else begin seq_err++; seq = 0; end
        end
        2: begin
          if (mem_req && mem_we && !mem_wdata[15] && mem_addr[1:0] == 2'd1) seq = 3;
          else begin seq_err++; seq = 0; end
        end
        default: begin
          if (!tx_int) seq_err++;
          seq = 0;
        end
      endcase
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int get_byte(input int ba);
    logic [15:0] w;
    w = mem[ba >> 1];
    return (ba % 2 == 1) ? int'(w[15:8]) : int'(w[7:0]);
  endfunction

  task automatic set_byte(input int ba, input logic [7:0] v);
    if (ba % 2 == 1) mem[ba >> 1][15:8] = v;
    else             mem[ba >> 1][7:0]  = v;
  endtask

  function automatic int exp_frame(input int len, input bit pad);
    return (pad && len < MIN_LEN) ? MIN_LEN : len;
  endfunction

  task automatic pulse_demand();
    @(negedge clk);
    tx_demand = 1'b1;
    @(negedge clk);
    tx_demand = 1'b0;
  endtask

  task automatic wait_idle();
    int quiet = 0;
    while (quiet < 6) begin
      @(negedge clk);
      if (!mem_req && !tx_valid && !tx_int) quiet++;
      else quiet = 0;
    end
  endtask

  task automatic write_desc(input int slot, input int ba, input int len, input logic [15:0] st);
    mem[RB + slot*4 + 0] = 16'(ba & 16'hFFFF);
    mem[RB + slot*4 + 1] = st | 16'((ba >> 16) & 8'hFF);
    mem[RB + slot*4 + 2] = 16'hF000 | 16'((4096 - len) & 12'hFFF);
    mem[RB + slot*4 + 3] = 16'hBEEF;
  endtask

  task automatic clear_mon(input int waddr);
    cap_n = 0; int_n = 0; wr_n = 0; seq_err = 0; watch_n = 0;
    watch_addr = waddr; first_addr = -1; armed = 1'b1;
  endtask

  int exp_idx = 0;
  int f_len [0:2];
  int f_odd [0:2];
  int f_ba  [0:2];

  task automatic do_run(input int n, input bit pad, input bit [2:0] rty, input bit pend_test);
    int stop_slot, e, bad_d, bad_p, bad_l;
    logic [15:0] exp_w1;
    pad_en = pad;
    {st_multi_retry, st_one_retry, st_defer} = rty;
    for (int k = 0; k < n; k++) begin
      int slot = (exp_idx + k) % NSLOT;
      f_ba[k] = BUF0 + slot*128 + f_odd[k];
      for (int j = 0; j < f_len[k]; j++) set_byte(f_ba[k] + j, 8'($urandom));
      write_desc(slot, f_ba[k], f_len[k], 16'h8300);
    end
    stop_slot = (exp_idx + n) % NSLOT;
    write_desc(stop_slot, BUF0, 1, 16'h0300);
    clear_mon(RB + stop_slot*4 + 1);
    pulse_demand();
    if (pend_test) begin
      while (!tx_valid) @(negedge clk);
      pulse_demand();
    end
    wait_idle();

    chk(first_addr == RB + exp_idx*4 + 1, "R2", "first read address", first_addr, RB + exp_idx*4 + 1);
    e = 0; bad_d = 0; bad_p = 0; bad_l = 0;
    for (int k = 0; k < n; k++) begin
      int fl = exp_frame(f_len[k], pad);
      for (int j = 0; j < fl; j++) begin
        int ev = (j < f_len[k]) ? get_byte(f_ba[k] + j) : 0;
        if (e < cap_n) begin
          if (int'(cap_data[e]) != ev) begin
            if (j < f_len[k]) bad_d++; else bad_p++;
          end
          if (cap_last[e] != (j == fl - 1)) bad_l++;
        end
        e++;
      end
    end
    chk(cap_n == e, "R6", "output byte count", cap_n, e);
    chk(bad_d == 0, "R4", "data byte mismatches", bad_d, 0);
    chk(bad_p == 0, "R6", "pad byte mismatches", bad_p, 0);
    chk(bad_l == 0, "R5", "last flag mismatches", bad_l, 0);
    chk(int_n == n, "R8", "interrupt count", int_n, n);
    chk(seq_err == 0, "R7", "write-back ordering errors", seq_err, 0);
    exp_w1 = 16'h0300 | (16'(rty) << 10);
    for (int k = 0; k < n; k++) begin
      int slot = (exp_idx + k) % NSLOT;
      chk(mem[RB + slot*4 + 3] == 16'h0, "R7", "error word", int'(mem[RB + slot*4 + 3]), 0);
      chk(mem[RB + slot*4 + 1] == exp_w1, "R7", "status word", int'(mem[RB + slot*4 + 1]), int'(exp_w1));
    end
    chk(watch_n == (pend_test ? 2 : 1), pend_test ? "R9" : "R8", "reads of stopping slot",
        watch_n, pend_test ? 2 : 1);
    chk(mem[RB + stop_slot*4 + 1] == 16'h0300, "R8", "host-owned slot untouched",
        int'(mem[RB + stop_slot*4 + 1]), 16'h0300);
    exp_idx = (exp_idx + n) % NSLOT;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
    end
  end

  initial begin
    int seed_v;
    seed_v = $urandom(32'h1d2c);
    for (int i = 0; i < 1024; i++) mem[i] = 16'h0;
    rst_n = 1'b0; tx_demand = 1'b0; pad_en = 1'b0;
    ring_base = 23'(RB);
    st_defer = 1'b0; st_one_retry = 1'b0; st_multi_retry = 1'b0;
    seq = 0; armed = 1'b0; watch_addr = -1;
    cap_n = 0; int_n = 0; wr_n = 0; seq_err = 0; watch_n = 0; first_addr = -1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1: idle after reset
    chk(!mem_req && !tx_valid && !tx_int, "R1", "outputs idle after reset",
        int'({mem_req, tx_valid, tx_int}), 0);

    // directed: odd start, no pad
    f_len[0] = 5;  f_odd[0] = 1; do_run(1, 1'b0, 3'b001, 1'b0);
    // short frame padded
    f_len[0] = 3;  f_odd[0] = 0; do_run(1, 1'b1, 3'b010, 1'b0);
    // pad boundary: 19, 20, 21
    f_len[0] = 19; f_odd[0] = 1; do_run(1, 1'b1, 3'b100, 1'b0);
    f_len[0] = 20; f_odd[0] = 0; do_run(1, 1'b1, 3'b000, 1'b0);
    f_len[0] = 21; f_odd[0] = 1; do_run(1, 1'b1, 3'b111, 1'b0);
    // single byte, no pad
    f_len[0] = 1;  f_odd[0] = 1; do_run(1, 1'b0, 3'b000, 1'b0);
    // three back to back, wraps the ring
    f_len[0] = 7; f_len[1] = 2; f_len[2] = 12;
    f_odd[0] = 0; f_odd[1] = 1; f_odd[2] = 1;
    do_run(3, 1'b1, 3'b011, 1'b0);

    // R3: owned but end-of-frame flag missing
    begin
      int slot = exp_idx;
      write_desc(slot, BUF0, 4, 16'h8200);
      write_desc((slot + 1) % NSLOT, BUF0, 1, 16'h0300);
      clear_mon(-1);
      pulse_demand();
      wait_idle();
      chk(cap_n == 0, "R3", "bytes from incomplete descriptor", cap_n, 0);
      chk(wr_n == 0, "R3", "writes for incomplete descriptor", wr_n, 0);
      chk(mem[RB + slot*4 + 1] == 16'h8200, "R3", "incomplete descriptor kept",
          int'(mem[RB + slot*4 + 1]), 16'h8200);
    end
    // R3: same slot serves the next poll (index kept)
    f_len[0] = 9; f_odd[0] = 0; do_run(1, 1'b0, 3'b101, 1'b0);

    // R9: demand during a frame
    f_len[0] = 30; f_odd[0] = 1; do_run(1, 1'b0, 3'b010, 1'b1);

    // random runs
    for (int r = 0; r < 25; r++) begin
      int n = 1 + int'($urandom % 3);
      for (int k = 0; k < 3; k++) begin
        f_len[k] = 1 + int'($urandom % 40);
        f_odd[k] = int'($urandom % 2);
      end
      do_run(n, 1'($urandom % 2), 3'($urandom % 8), 1'b0);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

endmodule